// File: doc/BRIEF.md
# Lane-Partitioned Operand Routing Window

This block holds the instruction window of one processing core and delivers producer results into the operand slots of consumer entries. The window has 128 entries. Each entry has a valid bit and two 64-bit operand slots, and each slot has its own present bit. The entries are split into four lane slices of 32 consecutive indices each: lane L owns indices L*32 through L*32+31. Every entry whose valid bit and both present bits are set is ready. For each active execution lane, the block offers the ready entry with the lowest index, together with both of its operands.

A mode bit arrives with each block load and is held until the next block load. In vector mode, all four lanes run. Each lane issues only from its own slice, and a result may only land in the slice of the entry that produced it. A result aimed at another slice is discarded and raises a routing error flag. In scalar mode, only two lanes issue. All 128 entries serve as one pool, split between the two issuing lanes by the lowest bit of the entry index. Any entry may deliver to any other, and lanes 2 and 3 never offer work. The ALUs that consume the offered entries are outside this block.

Top module: `lpw_window`

## Requirements
- R1: While reset is held and after reset is released, no entry is valid, `rdy_vld` is 0, `route_err` is 0, and `mode_vec` reads 1 (vector mode).
- R2: A `blk_load` pulse clears the valid bit and both present bits of every entry. It also latches `blk_vec_mode` into `mode_vec` (1 = vector, 0 = scalar), and that value is kept until the next block load.
- R3: An `inst_wr` pulse sets the valid bit of entry `inst_idx`. Setting the valid bit does not change the entry's present bits.
- R4: A result with `res_slot`=0 fills operand A, and a result with `res_slot`=1 fills operand B. An entry is ready only after it is valid and both of its operands have arrived, in any order.
- R5: In vector mode, lane L (L = 0..3) offers the lowest-index ready entry among indices L*32 .. L*32+31. The offer is made on `rdy_vld[L]` and on `rdy_idx[L*7 +: 7]`.
- R6: In vector mode, a result is discarded when bits [6:5] of `res_src` differ from bits [6:5] of `res_tgt`. The target's operand is left unchanged, and `route_err` is 1 in the cycle after the result was presented, for exactly one cycle.
- R7: In scalar mode, a result is delivered whatever its source and target, and `route_err` stays 0. Lane 0 offers the lowest-index ready entry among the even indices, lane 1 does the same among the odd indices, and `rdy_vld[3:2]` stays 0.
- R8: `iss_ack[L]`, when it coincides with `rdy_vld[L]`, clears the valid bit of the offered entry. When it does not coincide, it has no effect, and this includes lanes that are disabled in scalar mode.
- R9: For each lane that is offering, `iss_opa[L*64 +: 64]` and `iss_opb[L*64 +: 64]` carry the last data delivered to operand A and operand B of the offered entry.
- R10: When `blk_load` coincides with `inst_wr` or `res_vld`, the block load wins. The instruction load and the result are ignored, and no routing error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_load | input | 1 | Start of a new block: clears the window and latches the mode |
| blk_vec_mode | input | 1 | Mode of the incoming block (1 vector, 0 scalar) |
| inst_wr | input | 1 | Instruction load strobe |
| inst_idx | input | 7 | Window entry being loaded |
| res_vld | input | 1 | Result broadcast strobe |
| res_src | input | 7 | Window index of the producing entry |
| res_tgt | input | 7 | Window index of the consuming entry |
| res_slot | input | 1 | Target operand slot (0 = A, 1 = B) |
| res_data | input | 64 | Result value |
| iss_ack | input | 4 | Per-lane acceptance of the offered entry |
| rdy_vld | output | 4 | Per-lane ready entry available |
| rdy_idx | output | 28 | Per-lane offered entry index, 7 bits per lane |
| iss_opa | output | 256 | Per-lane operand A of the offered entry |
| iss_opb | output | 256 | Per-lane operand B of the offered entry |
| route_err | output | 1 | A vector-mode result crossed lanes and was dropped |
| mode_vec | output | 1 | Mode of the current block |

## Verification
The bench targets the points where domain membership changes with the mode. A design that decodes lane ownership from the wrong index bits would offer even and odd entries to the wrong lanes in scalar mode, or would accept cross-slice results in vector mode. A design that flags a cross-slice drop but still writes the operand, or that flags legal scalar deliveries, is caught by checking `route_err` and the operand data together. Further checks cover the following, each against the result a faulty design would give:
- Acknowledges on idle lanes or disabled lanes must not remove entries.
- A block load that coincides with other traffic must win.
- Present bits must not survive into the next block, which a design that forgot them would show by reporting stale entries as ready.

// File: rtl/lpw_pkg.sv
// Package: shared types for the lane-partitioned operand routing window.
// Assumes nothing beyond being compiled before the modules that import it.
package lpw_pkg;

    // Execution mode held for the block currently in the window.
    typedef enum logic {
        MODE_SCALAR = 1'b0,
        MODE_VECTOR = 1'b1
    } exec_mode_e;

endpackage

// File: rtl/lpw_router.sv
// Module: lpw_router
// Decides whether a broadcast result may be written into its target entry.
// In vector mode the source and target must share a lane slice (upper index
// bits); in scalar mode every delivery is permitted. A block load in the same
// cycle suppresses both the delivery and the error flag.
// Assumes NUM_LANES >= 2 and LANE_DEPTH a power of two.
module lpw_router #(
    parameter int NUM_LANES  = 4,
    parameter int LANE_DEPTH = 32,
    parameter int IDX_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_vec,
    input  logic             blk_load,
    input  logic             res_vld,
    input  logic [IDX_W-1:0] res_src,
    input  logic [IDX_W-1:0] res_tgt,
    output logic             dlv_en,
    output logic             route_err
);
    localparam int SLICE_W = $clog2(LANE_DEPTH);

    logic same_lane;
    logic permitted;
    logic drop_now;

    // Purpose: classify the incoming result as deliverable or dropped.
    always_comb begin
        same_lane = (res_src[IDX_W-1:SLICE_W] == res_tgt[IDX_W-1:SLICE_W]);
        permitted = !mode_vec || same_lane;
        dlv_en    = res_vld && !blk_load && permitted;
        drop_now  = res_vld && !blk_load && !permitted;
    end

    // Purpose: register the one-cycle routing error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) route_err <= 1'b0;
        else        route_err <= drop_now;
    end

    // R6: a dropped result is flagged in the next cycle only
    a_r6_flag_follows_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !blk_load && mode_vec &&
         res_src[IDX_W-1:SLICE_W] != res_tgt[IDX_W-1:SLICE_W]) |=> route_err);

    // R7: scalar-mode traffic never raises the flag
    a_r7_no_flag_scalar: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_vec) |=> !route_err);

endmodule

// File: rtl/lpw_entry_array.sv
// Module: lpw_entry_array
// Holds the valid bit, two present bits and two operand registers for every
// window entry. Block load has priority over instruction loads and deliveries;
// an instruction load wins over an issue clear of the same entry.
// Assumes dlv_en is already qualified by the router.
module lpw_entry_array #(
    parameter int ENTRIES = 128,
    parameter int IDX_W   = 7,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_load,
    input  logic              inst_wr,
    input  logic [IDX_W-1:0]  inst_idx,
    input  logic              dlv_en,
    input  logic [IDX_W-1:0]  dlv_idx,
    input  logic              dlv_slot,
    input  logic [DATA_W-1:0] dlv_data,
    input  logic [ENTRIES-1:0] iss_clr,
    output logic [ENTRIES-1:0] ready,
    output logic [DATA_W-1:0] op_a [ENTRIES],
    output logic [DATA_W-1:0] op_b [ENTRIES]
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] pa_q;
    logic [ENTRIES-1:0] pb_q;

    // Purpose: update valid and operand-present state of every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            pa_q    <= '0;
            pb_q    <= '0;
        end else if (blk_load) begin
            valid_q <= '0;
            pa_q    <= '0;
            pb_q    <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (inst_wr && inst_idx == IDX_W'(e)) valid_q[e] <= 1'b1;
                else if (iss_clr[e])                  valid_q[e] <= 1'b0;
                if (dlv_en && dlv_idx == IDX_W'(e)) begin
                    if (dlv_slot) pb_q[e] <= 1'b1;
                    else          pa_q[e] <= 1'b1;
                end
            end
        end
    end

    // Purpose: capture operand data for delivered results.
    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (dlv_en && dlv_idx == IDX_W'(e)) begin
                if (dlv_slot) op_b[e] <= dlv_data;
                else          op_a[e] <= dlv_data;
            end
        end
    end

    // Purpose: an entry is ready when loaded and both operands are present.
    assign ready = valid_q & pa_q & pb_q;

    // R2: a block load leaves no valid or present bit behind
    a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        blk_load |=> (valid_q == '0 && pa_q == '0 && pb_q == '0));

    // R3: an instruction load marks its entry valid
    a_r3_load_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_wr && !blk_load) |=> valid_q[$past(inst_idx)]);

endmodule

// File: rtl/lpw_issue_pick.sv
// Module: lpw_issue_pick
// For each lane, selects the lowest-index ready entry within the lane's
// domain and presents its operands. Domain: in vector mode the lane's
// contiguous slice; in scalar mode the entries whose index modulo SCALAR_ALUS
// equals the lane number, with lanes at or above SCALAR_ALUS idle.
// Also turns accepted offers into per-entry issue clears.
module lpw_issue_pick #(
    parameter int NUM_LANES   = 4,
    parameter int LANE_DEPTH  = 32,
    parameter int SCALAR_ALUS = 2,
    parameter int IDX_W       = 7,
    parameter int DATA_W      = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_vec,
    input  logic [NUM_LANES*LANE_DEPTH-1:0] ready,
    input  logic [DATA_W-1:0]             op_a [NUM_LANES*LANE_DEPTH],
    input  logic [DATA_W-1:0]             op_b [NUM_LANES*LANE_DEPTH],
    input  logic [NUM_LANES-1:0]          iss_ack,
    output logic [NUM_LANES-1:0]          rdy_vld,
    output logic [NUM_LANES*IDX_W-1:0]    rdy_idx,
    output logic [NUM_LANES*DATA_W-1:0]   opa,
    output logic [NUM_LANES*DATA_W-1:0]   opb,
    output logic [NUM_LANES*LANE_DEPTH-1:0] iss_clr
);
    localparam int ENTRIES = NUM_LANES * LANE_DEPTH;
    localparam int SLICE_W = $clog2(LANE_DEPTH);

    // Membership of entry e in the domain of lane ln under the given mode.
    function automatic logic in_domain(input int ln, input int e, input logic vec);
        if (vec) return ((e >> SLICE_W) == ln);
        return (ln < SCALAR_ALUS) && ((e % SCALAR_ALUS) == ln);
    endfunction

    for (genvar L = 0; L < NUM_LANES; L++) begin : g_lane
        logic             hit;
        logic [IDX_W-1:0] pick;

        // Purpose: priority-select the lowest-index ready entry of this lane.
        always_comb begin
            hit  = 1'b0;
            pick = '0;
            for (int e = ENTRIES - 1; e >= 0; e--) begin
                if (ready[e] && in_domain(L, e, mode_vec)) begin
                    hit  = 1'b1;
                    pick = IDX_W'(e);
                end
            end
        end

        assign rdy_vld[L]                 = hit;
        assign rdy_idx[L*IDX_W +: IDX_W]  = pick;
        assign opa[L*DATA_W +: DATA_W]    = op_a[pick];
        assign opb[L*DATA_W +: DATA_W]    = op_b[pick];

        // R4: an offered entry is genuinely ready
        a_r4_offer_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> ready[pick]);

        // R5: in vector mode an offer stays inside the lane slice
        a_r5_offer_in_slice: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && mode_vec) |-> (int'(pick >> SLICE_W) == L));
    end

    // Purpose: convert accepted offers into per-entry valid clears.
    always_comb begin
        iss_clr = '0;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (iss_ack[l] && rdy_vld[l])
                iss_clr[rdy_idx[l*IDX_W +: IDX_W]] = 1'b1;
        end
    end

endmodule

// File: rtl/lpw_window.sv
// Module: lpw_window (top)
// Instruction window split into lane slices with mode-dependent operand
// routing and per-lane ready selection. The mode register resets to vector
// mode and is reloaded on each block load.
// Assumes NUM_LANES >= 2, LANE_DEPTH and SCALAR_ALUS powers of two,
// SCALAR_ALUS <= NUM_LANES.
module lpw_window
    import lpw_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int LANE_DEPTH  = 32,
    parameter int SCALAR_ALUS = 2,
    parameter int DATA_W      = 64,
    localparam int ENTRIES    = NUM_LANES * LANE_DEPTH,
    localparam int IDX_W      = $clog2(ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        blk_load,
    input  logic                        blk_vec_mode,
    input  logic                        inst_wr,
    input  logic [IDX_W-1:0]            inst_idx,
    input  logic                        res_vld,
    input  logic [IDX_W-1:0]            res_src,
    input  logic [IDX_W-1:0]            res_tgt,
    input  logic                        res_slot,
    input  logic [DATA_W-1:0]           res_data,
    input  logic [NUM_LANES-1:0]        iss_ack,
    output logic [NUM_LANES-1:0]        rdy_vld,
    output logic [NUM_LANES*IDX_W-1:0]  rdy_idx,
    output logic [NUM_LANES*DATA_W-1:0] iss_opa,
    output logic [NUM_LANES*DATA_W-1:0] iss_opb,
    output logic                        route_err,
    output logic                        mode_vec
);
    exec_mode_e         mode_q;
    logic               dlv_en;
    logic [ENTRIES-1:0] ready;
    logic [ENTRIES-1:0] iss_clr;
    logic [DATA_W-1:0]  op_a [ENTRIES];
    logic [DATA_W-1:0]  op_b [ENTRIES];

    // Purpose: latch the execution mode of the block being loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= MODE_VECTOR;
        else if (blk_load) mode_q <= exec_mode_e'(blk_vec_mode);
    end

    assign mode_vec = (mode_q == MODE_VECTOR);

    lpw_router #(
        .NUM_LANES  (NUM_LANES),
        .LANE_DEPTH (LANE_DEPTH),
        .IDX_W      (IDX_W)
    ) u_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_vec  (mode_vec),
        .blk_load  (blk_load),
        .res_vld   (res_vld),
        .res_src   (res_src),
        .res_tgt   (res_tgt),
        .dlv_en    (dlv_en),
        .route_err (route_err)
    );

    lpw_entry_array #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .DATA_W  (DATA_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_load (blk_load),
        .inst_wr  (inst_wr),
        .inst_idx (inst_idx),
        .dlv_en   (dlv_en),
        .dlv_idx  (res_tgt),
        .dlv_slot (res_slot),
        .dlv_data (res_data),
        .iss_clr  (iss_clr),
        .ready    (ready),
        .op_a     (op_a),
        .op_b     (op_b)
    );

    lpw_issue_pick #(
        .NUM_LANES   (NUM_LANES),
        .LANE_DEPTH  (LANE_DEPTH),
        .SCALAR_ALUS (SCALAR_ALUS),
        .IDX_W       (IDX_W),
        .DATA_W      (DATA_W)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_vec (mode_vec),
        .ready    (ready),
        .op_a     (op_a),
        .op_b     (op_b),
        .iss_ack  (iss_ack),
        .rdy_vld  (rdy_vld),
        .rdy_idx  (rdy_idx),
        .opa      (iss_opa),
        .opb      (iss_opb),
        .iss_clr  (iss_clr)
    );

    // R7: lanes beyond the scalar ALU count never offer in scalar mode
    a_r7_scalar_lanes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_vec |-> ((rdy_vld >> SCALAR_ALUS) == '0));

    // R8: an accepted offer on lane 0 is not offered again
    a_r8_issue_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_ack[0] && rdy_vld[0] && !blk_load &&
         !(inst_wr && inst_idx == rdy_idx[IDX_W-1:0]))
        |=> !(rdy_vld[0] && rdy_idx[IDX_W-1:0] == $past(rdy_idx[IDX_W-1:0])));

    // R10: a block load wins over a coincident result, so nothing is flagged
    a_r10_load_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        blk_load |=> !route_err);

endmodule

// File: tb/tb_lpw_window.sv
module tb_lpw_window;
    localparam int NL = 4;
    localparam int IW = 7;
    localparam int DW = 64;

    localparam logic [1:0] K_BLK = 2'd0;
    localparam logic [1:0] K_INS = 2'd1;
    localparam logic [1:0] K_RES = 2'd2;
    localparam logic [1:0] K_ACK = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic        mode;
        logic [6:0]  tgt;
        logic [6:0]  src;
        logic        slot;
        logic [15:0] dat;
        logic [3:0]  evld;
        logic [1:0]  elane;
        logic [6:0]  eidx;
        logic        eerr;
    } row_t;

    localparam int NROWS = 34;
    localparam row_t TBL [NROWS] = '{
        '{K_BLK, 1'b1, 7'd0,   7'd0,   1'b0, 16'h0000, 4'b0000, 2'd0, 7'd0,   1'b0},
        '{K_INS, 1'b1, 7'd5,   7'd0,   1'b0, 16'h0000, 4'b0000, 2'd0, 7'd0,   1'b0},
        '{K_RES, 1'b1, 7'd5,   7'd3,   1'b0, 16'h00A1, 4'b0000, 2'd0, 7'd0,   1'b0},
        '{K_RES, 1'b1, 7'd5,   7'd10,  1'b1, 16'h00B1, 4'b0001, 2'd0, 7'd5,   1'b0},
        '{K_INS, 1'b1, 7'd2,   7'd0,   1'b0, 16'h0000, 4'b0001, 2'd0, 7'd5,   1'b0},
        '{K_RES, 1'b1, 7'd2,   7'd0,   1'b0, 16'h00A2, 4'b0001, 2'd0, 7'd5,   1'b0},
        '{K_RES, 1'b1, 7'd2,   7'd0,   1'b1, 16'h00B2, 4'b0001, 2'd0, 7'd2,   1'b0},
        '{K_RES, 1'b1, 7'd2,   7'd40,  1'b0, 16'hDEAD, 4'b0001, 2'd0, 7'd2,   1'b1},
        '{K_INS, 1'b1, 7'd33,  7'd0,   1'b0, 16'h0000, 4'b0001, 2'd0, 7'd2,   1'b0},
        '{K_RES, 1'b1, 7'd33,  7'd32,  1'b0, 16'h0333, 4'b0001, 2'd0, 7'd2,   1'b0},
        '{K_RES, 1'b1, 7'd33,  7'd63,  1'b1, 16'h0334, 4'b0011, 2'd1, 7'd33,  1'b0},
        '{K_INS, 1'b1, 7'd100, 7'd0,   1'b0, 16'h0000, 4'b0011, 2'd1, 7'd33,  1'b0},
        '{K_RES, 1'b1, 7'd100, 7'd96,  1'b0, 16'h1000, 4'b0011, 2'd1, 7'd33,  1'b0},
        '{K_RES, 1'b1, 7'd100, 7'd127, 1'b1, 16'h1001, 4'b1011, 2'd3, 7'd100, 1'b0},
        '{K_ACK, 1'b1, 7'd0,   7'd0,   1'b0, 16'h0000, 4'b1011, 2'd0, 7'd5,   1'b0},
        '{K_ACK, 1'b1, 7'd0,   7'd2,   1'b0, 16'h0000, 4'b1011, 2'd0, 7'd5,   1'b0},
        '{K_ACK, 1'b1, 7'd0,   7'd1,   1'b0, 16'h0000, 4'b1001, 2'd3, 7'd100, 1'b0},
        '{K_BLK, 1'b0, 7'd0,   7'd0,   1'b0, 16'h0000, 4'b0000, 2'd0, 7'd0,   1'b0},
        '{K_INS, 1'b0, 7'd6,   7'd0,   1'b0, 16'h0000, 4'b0000, 2'd0, 7'd0,   1'b0},
        '{K_RES, 1'b0, 7'd6,   7'd127, 1'b0, 16'h0600, 4'b0000, 2'd0, 7'd0,   1'b0},
        '{K_RES, 1'b0, 7'd6,   7'd1,   1'b1, 16'h0601, 4'b0001, 2'd0, 7'd6,   1'b0},
        '{K_INS, 1'b0, 7'd9,   7'd0,   1'b0, 16'h0000, 4'b0001, 2'd0, 7'd6,   1'b0},
        '{K_RES, 1'b0, 7'd9,   7'd6,   1'b0, 16'h0900, 4'b0001, 2'd0, 7'd6,   1'b0},
        '{K_RES, 1'b0, 7'd9,   7'd100, 1'b1, 16'h0901, 4'b0011, 2'd1, 7'd9,   1'b0},
        '{K_INS, 1'b0, 7'd4,   7'd0,   1'b0, 16'h0000, 4'b0011, 2'd1, 7'd9,   1'b0},
        '{K_RES, 1'b0, 7'd4,   7'd64,  1'b0, 16'h0400, 4'b0011, 2'd1, 7'd9,   1'b0},
        '{K_RES, 1'b0, 7'd4,   7'd3,   1'b1, 16'h0401, 4'b0011, 2'd0, 7'd4,   1'b0},
        '{K_ACK, 1'b0, 7'd0,   7'd3,   1'b0, 16'h0000, 4'b0011, 2'd0, 7'd4,   1'b0},
        '{K_ACK, 1'b0, 7'd0,   7'd0,   1'b0, 16'h0000, 4'b0011, 2'd0, 7'd6,   1'b0},
        '{K_ACK, 1'b0, 7'd0,   7'd1,   1'b0, 16'h0000, 4'b0001, 2'd0, 7'd6,   1'b0},
        '{K_BLK, 1'b1, 7'd0,   7'd0,   1'b0, 16'h0000, 4'b0000, 2'd0, 7'd0,   1'b0},
        '{K_INS, 1'b1, 7'd70,  7'd0,   1'b0, 16'h0000, 4'b0000, 2'd0, 7'd0,   1'b0},
        '{K_RES, 1'b1, 7'd70,  7'd65,  1'b0, 16'h7000, 4'b0000, 2'd0, 7'd0,   1'b0},
        '{K_RES, 1'b1, 7'd70,  7'd95,  1'b1, 16'h7001, 4'b0100, 2'd2, 7'd70,  1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              blk_load = 1'b0;
    logic              blk_vec_mode = 1'b0;
    logic              inst_wr = 1'b0;
    logic [IW-1:0]     inst_idx = '0;
    logic              res_vld = 1'b0;
    logic [IW-1:0]     res_src = '0;
    logic [IW-1:0]     res_tgt = '0;
    logic              res_slot = 1'b0;
    logic [DW-1:0]     res_data = '0;
    logic [NL-1:0]     iss_ack = '0;
    logic [NL-1:0]     rdy_vld;
    logic [NL*IW-1:0]  rdy_idx;
    logic [NL*DW-1:0]  iss_opa;
    logic [NL*DW-1:0]  iss_opb;
    logic              route_err;
    logic              mode_vec;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_mode = 1'b1;

    always #5 clk = ~clk;

    lpw_window dut (
        .clk(clk), .rst_n(rst_n), .blk_load(blk_load), .blk_vec_mode(blk_vec_mode),
        .inst_wr(inst_wr), .inst_idx(inst_idx), .res_vld(res_vld), .res_src(res_src),
        .res_tgt(res_tgt), .res_slot(res_slot), .res_data(res_data), .iss_ack(iss_ack),
        .rdy_vld(rdy_vld), .rdy_idx(rdy_idx), .iss_opa(iss_opa), .iss_opb(iss_opb),
        .route_err(route_err), .mode_vec(mode_vec)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock with the currently driven pulses, then release them.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        blk_load = 1'b0; inst_wr = 1'b0; res_vld = 1'b0; iss_ack = '0;
    endtask

    task automatic do_res(input logic [6:0] src, input logic [6:0] tgt,
                          input logic slot, input logic [63:0] d);
        res_vld = 1'b1; res_src = src; res_tgt = tgt; res_slot = slot; res_data = d;
        tick();
    endtask

    task automatic do_ins(input logic [6:0] idx);
        inst_wr = 1'b1; inst_idx = idx;
        tick();
    endtask

    task automatic do_blk(input logic m);
        blk_load = 1'b1; blk_vec_mode = m; exp_mode = m;
        tick();
    endtask

    // Watchdog: a hung run is a failure that still reaches the summary.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1 rdy_vld in reset", 64'(rdy_vld), 64'd0);
        chk("R1 route_err in reset", 64'(route_err), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdy_vld after reset", 64'(rdy_vld), 64'd0);
        chk("R1 mode after reset", 64'(mode_vec), 64'd1);

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NROWS; i++) begin
            row_t r = TBL[i];
            case (r.kind)
                K_BLK: begin blk_load = 1'b1; blk_vec_mode = r.mode; exp_mode = r.mode; end
                K_INS: begin inst_wr = 1'b1; inst_idx = r.tgt; end
                K_RES: begin
                    res_vld = 1'b1; res_src = r.src; res_tgt = r.tgt;
                    res_slot = r.slot; res_data = {4{r.dat}};
                end
                default: iss_ack = NL'(1) << r.src[1:0];
            endcase
            tick();
            chk($sformatf("R5/R7/R8 row %0d rdy_vld", i), 64'(rdy_vld), 64'(r.evld));
            chk($sformatf("R6 row %0d route_err", i), 64'(route_err), 64'(r.eerr));
            chk($sformatf("R2 row %0d mode", i), 64'(mode_vec), 64'(exp_mode));
            if (r.evld[r.elane])
                chk($sformatf("R5/R7 row %0d rdy_idx lane %0d", i, r.elane),
                    64'(rdy_idx[r.elane*IW +: IW]), 64'(r.eidx));
        end

        // R9: operand data travels to the offering lane
        do_blk(1'b1);
        do_ins(7'd7);
        do_res(7'd1, 7'd7, 1'b0, 64'h1111_2222_3333_4444);
        do_res(7'd31, 7'd7, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD);
        chk("R9 lane0 idx", 64'(rdy_idx[IW-1:0]), 64'd7);
        chk("R9 opa", iss_opa[63:0], 64'h1111_2222_3333_4444);
        chk("R9 opb", iss_opb[63:0], 64'hAAAA_BBBB_CCCC_DDDD);
        // R6: cross-lane write is dropped and leaves data untouched
        do_res(7'd40, 7'd7, 1'b0, 64'h9999_9999_9999_9999);
        chk("R6 drop flag", 64'(route_err), 64'd1);
        chk("R6 opa kept", iss_opa[63:0], 64'h1111_2222_3333_4444);
        @(negedge clk);
        chk("R6 flag is one cycle", 64'(route_err), 64'd0);

        // R10: block load beats coincident instruction load and result
        blk_load = 1'b1; blk_vec_mode = 1'b1; exp_mode = 1'b1;
        inst_wr = 1'b1; inst_idx = 7'd12;
        res_vld = 1'b1; res_src = 7'd40; res_tgt = 7'd12; res_slot = 1'b0;
        tick();
        chk("R10 nothing ready", 64'(rdy_vld), 64'd0);
        chk("R10 no flag", 64'(route_err), 64'd0);
        // R2: present bits were cleared, so re-validating is not enough
        do_ins(7'd12);
        do_ins(7'd7);
        chk("R2 stale operands cleared", 64'(rdy_vld), 64'd0);
        // R3: validity alone does not make ready; operands complete it
        do_res(7'd0, 7'd12, 1'b1, 64'h5);
        chk("R4 one operand only", 64'(rdy_vld), 64'd0);
        do_res(7'd0, 7'd12, 1'b0, 64'h6);
        chk("R3 loaded entry ready", 64'(rdy_vld), 64'd1);
        chk("R3 loaded entry idx", 64'(rdy_idx[IW-1:0]), 64'd12);

        // R1: mid-run reset empties the window and restores vector mode
        do_blk(1'b0);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdy after mid reset", 64'(rdy_vld), 64'd0);
        chk("R1 mode after mid reset", 64'(mode_vec), 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule